// File: doc/BRIEF.md
# Fuse packet map decoder

The decoder walks the contents of a one-time-programmable fuse array from address 0 upward, one byte per request. It turns a packed stream of packets into a flat logical map. Each packet opens with a header that names a target section and carries a four-bit mask of which words of that section follow. The header is either one byte, or two bytes through an escape code when the section number needs more than four bits. The words that follow are two bytes each, low byte first. Decoding ends at the first blank header byte or at the end of the usable area.

Software or a boot sequencer pulses `start_i`. The block then reads bytes through a request/acknowledge port until it stops. It raises `done_o` and reports how many fuse bytes belonged to packets. After that, any byte of the 16-section by 4-word map can be read through a synchronous read port. A decode can be started again at any time once the block is idle or done, and the map is cleared to all ones at each start.

Top module: `fuse_map_decoder`

## Requirements
- R1: After reset `done_o` and `fuse_req_o` are 0, `used_bytes_o` is 0, and every map byte reads 0xFF.
- R2: Each start sets every logical word to 0xFFFF, so any section or word not written by the current decode reads 0xFF in both bytes, whatever an earlier decode left.
- R3: If the byte at fuse address 0 is 0xFF, decoding ends after that single read, with `done_o` = 1 and `used_bytes_o` = 0.
- R4: A header byte whose bits 4:0 are not 0b01111 is a one-byte header: bits 7:4 are the section and bits 3:0 the word mask.
- R5: A header byte whose bits 4:0 equal 0b01111 is extended: section bits 2:0 are header bits 7:5, and section bits 6:3 are bits 7:4 of the next byte. The low nibble of the next byte is the word mask.
- R6: An extended header whose mask nibble is 0xF carries no data, and the byte after it is read as the next header. A one-byte header with mask 0xF also carries no data.
- R7: A mask bit of 0 marks word i as present. Present words are taken in order 0 to 3, two bytes each, low byte first. Word w of section s appears at map byte address s*8 + w*2 (low) and s*8 + w*2 + 1 (high).
- R8: The data words of a packet whose section is 16 or more are read and counted, but they change no map byte.
- R9: Decoding stops at a header byte equal to 0xFF. `used_bytes_o` then equals the number of header and data bytes consumed, without the terminating byte.
- R10: No byte at address LIMIT or above is requested. When the address reaches LIMIT, decoding stops with `used_bytes_o` = LIMIT, and a word whose high byte would lie at LIMIT is not written.
- R11: `fuse_req_o` stays high with `fuse_addr_o` unchanged until `fuse_ack_i` is seen. Each acknowledged byte that is not a terminating header advances the address by one, so every fuse byte is read exactly once.
- R12: `done_o` stays high until the next start. `map_rdata_o` shows the byte at `map_raddr_i` from the clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a decode (accepted when idle or done) |
| fuse_req_o | output | 1 | Byte read request to the fuse array |
| fuse_addr_o | output | $clog2(LIMIT+1) | Fuse byte address of the request |
| fuse_ack_i | input | 1 | Read data valid, one cycle per request |
| fuse_data_i | input | 8 | Fuse byte returned with the acknowledge |
| map_raddr_i | input | $clog2(SECTIONS*8) | Logical map byte address |
| map_rdata_o | output | 8 | Logical map byte, registered |
| done_o | output | 1 | Decode finished |
| used_bytes_o | output | $clog2(LIMIT+1) | Fuse bytes consumed by packets |

## Verification
The sharpest coincidence is the last data byte arriving at address LIMIT-1. In that one cycle it both completes a map word write and drives the address to the stop limit. A layout that ends a two-word packet exactly at the limit provokes it, and the bench requires the word to be stored, `used_bytes_o` to equal LIMIT and no request at LIMIT. A second layout puts only a low byte before the limit and requires that word to stay 0xFF. A further pairing is a restart over a map that holds old data: the clear at start and the first writes must not mix. It is judged by decoding an empty array right after a full one and expecting an all-ones map.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_EXT,
    ST_LO,
    ST_HI,
    ST_DONE
  } fmd_state_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam logic [4:0] EXT_TAG    = 5'b01111;
  localparam int         WORDS_PER  = 4;
  localparam int         SECT_BITS  = 7;
endpackage

// File: rtl/fmd_hdr_decode.sv
module fmd_hdr_decode
  import fmd_pkg::*;
(
  input  logic [7:0]           byte_i,
  input  logic [2:0]           ext_lo_i,
  output logic                 blank_o,
  output logic                 ext_o,
  output logic [SECT_BITS-1:0] norm_sect_o,
  output logic [SECT_BITS-1:0] ext_sect_o,
  output logic [3:0]           mask_o
);
  assign blank_o     = (byte_i == BLANK_BYTE);
  assign ext_o       = (byte_i[4:0] == EXT_TAG);
  assign norm_sect_o = {3'b000, byte_i[7:4]};
  // second byte of an extended header supplies the upper section bits
  assign ext_sect_o  = {byte_i[7:4], ext_lo_i};
  assign mask_o      = byte_i[3:0];
endmodule

// File: rtl/fmd_word_pick.sv
module fmd_word_pick (
  input  logic [3:0] mask_i,
  output logic       any_o,
  output logic [1:0] idx_o
);
  // lowest word whose mask bit is 0
  always_comb begin
    idx_o = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (!mask_i[i]) idx_o = i[1:0];
    end
  end
  assign any_o = (mask_i != 4'hF);
endmodule

// File: rtl/fmd_parser.sv
module fmd_parser
  import fmd_pkg::*;
#(
  parameter  int LIMIT    = 256,
  parameter  int SECTIONS = 16,
  localparam int ADDR_W   = $clog2(LIMIT + 1),
  localparam int SIDX_W   = $clog2(SECTIONS),
  localparam int WIDX_W   = SIDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              fuse_req_o,
  output logic [ADDR_W-1:0] fuse_addr_o,
  input  logic              fuse_ack_i,
  input  logic [7:0]        fuse_data_i,
  output logic              clear_o,
  output logic              wr_en_o,
  output logic [WIDX_W-1:0] wr_idx_o,
  output logic [15:0]       wr_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] used_o
);
  localparam logic [ADDR_W-1:0]    LIM     = ADDR_W'(LIMIT);
  localparam logic [SECT_BITS-1:0] SEC_LIM = SECT_BITS'(SECTIONS);

  fmd_state_e           state_q, state_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [SECT_BITS-1:0] sect_q, sect_d;
  logic [3:0]           mask_q, mask_d;
  logic [1:0]           widx_q, widx_d;
  logic [7:0]           lo_q, lo_d;
  logic [2:0]           ext_lo_q, ext_lo_d;

  logic                 at_lim, busy, take;
  logic                 hd_blank, hd_ext;
  logic [SECT_BITS-1:0] hd_norm, hd_esect;
  logic [3:0]           hd_mask, pick_mask;
  logic                 pk_any;
  logic [1:0]           pk_idx;

  fmd_hdr_decode u_hdr (
    .byte_i      (fuse_data_i),
    .ext_lo_i    (ext_lo_q),
    .blank_o     (hd_blank),
    .ext_o       (hd_ext),
    .norm_sect_o (hd_norm),
    .ext_sect_o  (hd_esect),
    .mask_o      (hd_mask)
  );

  // after a word, retire its mask bit and look for the next one
  assign pick_mask = (state_q == ST_HI) ? (mask_q | (4'b0001 << widx_q)) : hd_mask;

  fmd_word_pick u_pick (
    .mask_i (pick_mask),
    .any_o  (pk_any),
    .idx_o  (pk_idx)
  );

  assign at_lim      = (addr_q >= LIM);
  assign busy        = (state_q == ST_HDR) || (state_q == ST_EXT) ||
                       (state_q == ST_LO)  || (state_q == ST_HI);
  assign fuse_req_o  = busy && !at_lim;
  assign take        = fuse_req_o && fuse_ack_i;
  assign fuse_addr_o = addr_q;
  assign done_o      = (state_q == ST_DONE);
  assign used_o      = addr_q;
  assign wr_idx_o    = {sect_q[SIDX_W-1:0], widx_q};
  assign wr_data_o   = {fuse_data_i, lo_q};

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    sect_d   = sect_q;
    mask_d   = mask_q;
    widx_d   = widx_q;
    lo_d     = lo_q;
    ext_lo_d = ext_lo_q;
    clear_o  = 1'b0;
    wr_en_o  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          clear_o = 1'b1;
          addr_d  = '0;
          state_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (at_lim) begin
          state_d = ST_DONE;
        end else if (take) begin
          if (hd_blank) begin
            state_d = ST_DONE;
          end else begin
            addr_d = addr_q + 1'b1;
            if (hd_ext) begin
              ext_lo_d = fuse_data_i[7:5];
              state_d  = ST_EXT;
            end else begin
              sect_d  = hd_norm;
              mask_d  = hd_mask;
              widx_d  = pk_idx;
              state_d = pk_any ? ST_LO : ST_HDR;
            end
          end
        end
      end
      ST_EXT: begin
        if (at_lim) begin
          state_d = ST_DONE;
        end else if (take) begin
          addr_d  = addr_q + 1'b1;
          sect_d  = hd_esect;
          mask_d  = hd_mask;
          widx_d  = pk_idx;
          state_d = pk_any ? ST_LO : ST_HDR;
        end
      end
      ST_LO: begin
        if (at_lim) begin
          state_d = ST_DONE;
        end else if (take) begin
          lo_d    = fuse_data_i;
          addr_d  = addr_q + 1'b1;
          state_d = ST_HI;
        end
      end
      ST_HI: begin
        if (at_lim) begin
          state_d = ST_DONE;  // low byte already held is dropped
        end else if (take) begin
          addr_d  = addr_q + 1'b1;
          wr_en_o = (sect_q < SEC_LIM);
          mask_d  = pick_mask;
          widx_d  = pk_idx;
          state_d = pk_any ? ST_LO : ST_HDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      sect_q   <= '0;
      mask_q   <= 4'hF;
      widx_q   <= '0;
      lo_q     <= '0;
      ext_lo_q <= '0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      sect_q   <= sect_d;
      mask_q   <= mask_d;
      widx_q   <= widx_d;
      lo_q     <= lo_d;
      ext_lo_q <= ext_lo_d;
    end
  end

  p_addr_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_req_o && !fuse_ack_i) |=> (fuse_req_o && $stable(fuse_addr_o)));

  p_addr_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_req_o && fuse_ack_i && fuse_data_i != BLANK_BYTE)
      |=> (fuse_addr_o == $past(fuse_addr_o) + 1'b1));

  p_no_req_at_limit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_o |-> (fuse_addr_o < LIM));

  p_done_no_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fuse_req_o);

  p_done_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_empty_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR && addr_q == '0 && take && fuse_data_i == BLANK_BYTE)
      |=> (done_o && used_o == '0));
endmodule

// File: rtl/fmd_map_store.sv
module fmd_map_store #(
  parameter  int SECTIONS = 16,
  localparam int NWORDS   = SECTIONS * 4,
  localparam int WIDX_W   = $clog2(SECTIONS) + 2,
  localparam int RADDR_W  = WIDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               wr_en_i,
  input  logic [WIDX_W-1:0]  wr_idx_i,
  input  logic [15:0]        wr_data_i,
  input  logic [RADDR_W-1:0] rd_addr_i,
  output logic [7:0]         rd_data_o
);
  logic [15:0] word_q [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      word_q[w] <= 16'hFFFF;
      else if (clear_i)                                 word_q[w] <= 16'hFFFF;
      else if (wr_en_i && wr_idx_i == WIDX_W'(w))       word_q[w] <= wr_data_i;
    end
  end

  logic [15:0] rd_word;
  assign rd_word = word_q[rd_addr_i[RADDR_W-1:1]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= 8'hFF;
    else         rd_data_o <= rd_addr_i[0] ? rd_word[15:8] : rd_word[7:0];
  end

  p_clear_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (word_q[0] == 16'hFFFF && word_q[NWORDS-1] == 16'hFFFF));
endmodule

// File: rtl/fuse_map_decoder.sv
module fuse_map_decoder #(
  parameter  int LIMIT    = 256,
  parameter  int SECTIONS = 16,
  localparam int ADDR_W   = $clog2(LIMIT + 1),
  localparam int WIDX_W   = $clog2(SECTIONS) + 2,
  localparam int MAP_AW   = WIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              fuse_req_o,
  output logic [ADDR_W-1:0] fuse_addr_o,
  input  logic              fuse_ack_i,
  input  logic [7:0]        fuse_data_i,
  input  logic [MAP_AW-1:0] map_raddr_i,
  output logic [7:0]        map_rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] used_bytes_o
);
  logic              clear;
  logic              wr_en;
  logic [WIDX_W-1:0] wr_idx;
  logic [15:0]       wr_data;

  fmd_parser #(.LIMIT(LIMIT), .SECTIONS(SECTIONS)) u_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .fuse_req_o  (fuse_req_o),
    .fuse_addr_o (fuse_addr_o),
    .fuse_ack_i  (fuse_ack_i),
    .fuse_data_i (fuse_data_i),
    .clear_o     (clear),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .done_o      (done_o),
    .used_o      (used_bytes_o)
  );

  fmd_map_store #(.SECTIONS(SECTIONS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_addr_i (map_raddr_i),
    .rd_data_o (map_rdata_o)
  );
endmodule

// File: tb/fuse_map_decoder_test.sv
module fuse_map_decoder_test;
  localparam int LIMIT    = 32;
  localparam int SECTIONS = 16;
  localparam int AW       = $clog2(LIMIT + 1);
  localparam int MAW      = $clog2(SECTIONS * 8);
  localparam int MAPN     = SECTIONS * 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           fuse_req;
  logic [AW-1:0]  fuse_addr;
  logic           fuse_ack = 1'b0;
  logic [7:0]     fuse_data = 8'h00;
  logic [MAW-1:0] map_raddr = '0;
  logic [7:0]     map_rdata;
  logic           done;
  logic [AW-1:0]  used;

  logic [7:0] fmem    [64];
  logic [7:0] exp_map [MAPN];
  int fuse_lat = 0;
  int reads = 0;
  int max_addr = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fuse_map_decoder #(.LIMIT(LIMIT), .SECTIONS(SECTIONS)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .fuse_req_o   (fuse_req),
    .fuse_addr_o  (fuse_addr),
    .fuse_ack_i   (fuse_ack),
    .fuse_data_i  (fuse_data),
    .map_raddr_i  (map_raddr),
    .map_rdata_o  (map_rdata),
    .done_o       (done),
    .used_bytes_o (used)
  );

  // fuse array model
  initial begin
    forever begin
      @(negedge clk);
      if (fuse_ack) begin
        fuse_ack = 1'b0;
      end else if (fuse_req) begin
        repeat (fuse_lat) @(negedge clk);
        fuse_data = fmem[fuse_addr];
        fuse_ack  = 1'b1;
        reads++;
        if (int'(fuse_addr) > max_addr) max_addr = int'(fuse_addr);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic fuse_blank();
    for (int i = 0; i < 64; i++) fmem[i] = 8'hFF;
    for (int i = 0; i < MAPN; i++) exp_map[i] = 8'hFF;
  endtask

  task automatic read_byte(input int a, output logic [7:0] v);
    @(negedge clk);
    map_raddr = MAW'(a);
    @(negedge clk);
    v = map_rdata;
  endtask

  task automatic check_map(input string tag);
    int bad = 0;
    int first = 0;
    logic [7:0] v, fv, fe;
    fv = 8'h00;
    fe = 8'h00;
    for (int i = 0; i < MAPN; i++) begin
      read_byte(i, v);
      if (v !== exp_map[i]) begin
        if (bad == 0) begin first = i; fv = v; fe = exp_map[i]; end
        bad++;
      end
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s map[%0d] act=%0h exp=%0h (%0d bytes differ)", tag, first, fv, fe, bad);
    end
  endtask

  task automatic run_decode(input int lat);
    int cyc = 0;
    fuse_lat = lat;
    reads = 0;
    max_addr = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12 decode reaches done", 32'(done), 32'd1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 req after reset", 32'(fuse_req), 32'd0);
    chk("R1 used after reset", 32'(used), 32'd0);
    read_byte(0, v);
    chk("R1 map[0] after reset", 32'(v), 32'hFF);
    read_byte(MAPN - 1, v);
    chk("R1 map[last] after reset", 32'(v), 32'hFF);
  endtask

  task automatic t_normal();
    fuse_blank();
    fmem[0] = 8'h20;
    for (int k = 0; k < 8; k++) begin
      fmem[1 + k] = 8'h11 + 8'(k);
      exp_map[16 + k] = 8'h11 + 8'(k);
    end
    fmem[9] = 8'h5A;
    fmem[10] = 8'hA0; fmem[11] = 8'hA1; fmem[12] = 8'hB0; fmem[13] = 8'hB1;
    exp_map[40] = 8'hA0; exp_map[41] = 8'hA1; exp_map[44] = 8'hB0; exp_map[45] = 8'hB1;
    fmem[15] = 8'h33;
    run_decode(1);
    chk("R9 used after blank header", 32'(used), 32'd14);
    chk("R11 each byte read once", 32'(reads), 32'd15);
    check_map("R4 R7 one-byte headers");
  endtask

  task automatic t_read_latency();
    @(negedge clk);
    map_raddr = MAW'(16);
    @(posedge clk);
    #1;
    chk("R12 read data one edge after address", 32'(map_rdata), 32'h11);
    @(negedge clk);
    map_raddr = MAW'(17);
    #1;
    chk("R12 read data held before edge", 32'(map_rdata), 32'h11);
    @(negedge clk);
    chk("R12 read data after edge", 32'(map_rdata), 32'h12);
    repeat (10) @(negedge clk);
    chk("R12 done holds while idle", 32'(done), 32'd1);
  endtask

  task automatic t_empty();
    fuse_blank();
    fmem[1] = 8'h20;
    fmem[2] = 8'h00;
    run_decode(0);
    chk("R3 used on empty array", 32'(used), 32'd0);
    chk("R3 single read on empty array", 32'(reads), 32'd1);
    check_map("R2 map cleared at restart");
  endtask

  task automatic t_extended();
    fuse_blank();
    fmem[0] = 8'h6F; fmem[1] = 8'h1C;
    fmem[2] = 8'hC0; fmem[3] = 8'hC1; fmem[4] = 8'hD0; fmem[5] = 8'hD1;
    exp_map[88] = 8'hC0; exp_map[89] = 8'hC1; exp_map[90] = 8'hD0; exp_map[91] = 8'hD1;
    fmem[6] = 8'h0F; fmem[7] = 8'h2F;
    fmem[8] = 8'h2F; fmem[9] = 8'h30;
    for (int k = 0; k < 8; k++) fmem[10 + k] = 8'hE0 + 8'(k);
    fmem[18] = 8'h1E; fmem[19] = 8'hF0; fmem[20] = 8'hF1;
    exp_map[8] = 8'hF0; exp_map[9] = 8'hF1;
    run_decode(3);
    chk("R6 R8 used over skipped and dropped packets", 32'(used), 32'd21);
    chk("R11 reads over extended headers", 32'(reads), 32'd22);
    check_map("R5 R6 R8 extended headers");
  endtask

  task automatic t_mask_order();
    fuse_blank();
    fmem[0] = 8'h9F;
    fmem[1] = 8'h76;
    fmem[2] = 8'h01; fmem[3] = 8'h02; fmem[4] = 8'h03; fmem[5] = 8'h04;
    exp_map[56] = 8'h01; exp_map[57] = 8'h02; exp_map[62] = 8'h03; exp_map[63] = 8'h04;
    run_decode(0);
    chk("R6 R9 used with empty one-byte packet", 32'(used), 32'd6);
    check_map("R7 sparse mask word order");
  endtask

  task automatic fill_three();
    for (int s = 0; s < 3; s++) begin
      fmem[s * 9] = {4'(s), 4'h0};
      for (int k = 0; k < 8; k++) begin
        fmem[s * 9 + 1 + k] = 8'h40 + 8'(s * 8 + k);
        exp_map[s * 8 + k] = 8'h40 + 8'(s * 8 + k);
      end
    end
  endtask

  task automatic t_limit_full();
    fuse_blank();
    fill_three();
    fmem[27] = 8'h3C;
    fmem[28] = 8'hA1; fmem[29] = 8'hA2; fmem[30] = 8'hA3; fmem[31] = 8'hA4;
    exp_map[24] = 8'hA1; exp_map[25] = 8'hA2; exp_map[26] = 8'hA3; exp_map[27] = 8'hA4;
    fmem[32] = 8'h5E; fmem[33] = 8'h66;
    run_decode(2);
    chk("R10 used at limit", 32'(used), LIMIT);
    chk("R10 highest address read", 32'(max_addr), LIMIT - 1);
    chk("R11 reads up to limit", 32'(reads), LIMIT);
    check_map("R10 word completed at limit");
  endtask

  task automatic t_limit_cut();
    fuse_blank();
    fill_three();
    fmem[27] = 8'h3E; fmem[28] = 8'h77; fmem[29] = 8'h88;
    exp_map[24] = 8'h77; exp_map[25] = 8'h88;
    fmem[30] = 8'h4E; fmem[31] = 8'h99; fmem[32] = 8'hAA;
    run_decode(1);
    chk("R10 used with cut word", 32'(used), LIMIT);
    chk("R10 no read past limit", 32'(max_addr), LIMIT - 1);
    check_map("R10 cut word abandoned");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) fmem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_read_latency();
    t_empty();
    t_extended();
    t_mask_order();
    t_limit_full();
    t_limit_cut();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule